// File: doc/BRIEF.md
# Half-Flash Converter Bus Controller

This block is the digital sequencer and host-side interface of a multi-channel 8-bit converter that resolves each sample in two 4-bit flash steps. A host starts a conversion by pulling chip select and read low together. The block then latches the channel address and lets the comparators follow the input for a fixed tracking window. It captures the coarse (upper) nibble from one 15-comparator thermometer code and, after a second fixed window, captures the fine (lower) nibble from the residue comparators. At that point it signals completion on an active-low interrupt.

Two host styles are supported and chosen by a mode input. In the stalled mode the host holds read low for the whole conversion: the ready line holds the host in a wait state, and the data bus stays released until the result is available. In the pipelined mode each read starts a new conversion and at the same moment returns the result of the previous one, so no wait state is needed. Both windows are given in nanoseconds and converted to system-clock cycles by parameters. With the defaults, the 1000 ns and 600 ns windows at a 4 ns clock give 250 and 150 cycles.

Top module: `hfadc_bus_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, int_n is 1, data_oe is 0, ready_drive is 0 and data_out is 0x00.
- R2: A conversion starts on the first clock edge at which cs_n and rd_n are both sampled low after they were not both low on the previous edge, provided no conversion is in progress. At that edge chan_addr is copied to chan_sel, which then holds its value until the next accepted start.
- R3: The coarse code is sampled at the clock edge TRACK_NS/CLK_NS cycles after the start edge, and gives the upper nibble (bits 7:4). The fine code is sampled FINE_NS/CLK_NS cycles after that edge and gives the lower nibble (bits 3:0). The 8-bit result is updated only at this second edge.
- R4: A 15-bit thermometer code is converted by counting consecutive ones upward from bit 0 and stopping at the first zero. Ones above that zero (bubbles) are ignored, so 0x005F decodes to 5.
- R5: All-zero codes on both banks give result 0x00 (lower reference), and all-ones codes on both give 0xFF (upper reference).
- R6: int_n goes to 0 at the edge that completes a conversion. It returns to 1 at the first edge at which cs_n and rd_n are no longer both low after having been both low on the previous edge. If both events fall on the same edge, completion wins.
- R7: With mode_pipe = 0, data_oe is 1 only while cs_n and rd_n are low, were low on the previous edge, and no conversion is in progress. data_out then carries the latest result.
- R8: With mode_pipe = 0, ready_drive is 1 while cs_n is low, from the falling edge of cs_n or from a new start, until the edge that completes the conversion.
- R9: With mode_pipe = 1, data_oe equals (cs_n and rd_n both low), and data_out shows the result of the last completed conversion, not the one being started.
- R10: With mode_pipe = 1, ready_drive equals not cs_n.
- R11: A new read access during a conversion does not restart it, does not change chan_sel, and does not move the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| chan_addr | input | AW | Channel address offered by the host |
| mode_pipe | input | 1 | 0 = stalled read, 1 = pipelined read |
| coarse_therm | input | 15 | Thermometer code from the upper-nibble comparators |
| fine_therm | input | 15 | Thermometer code from the residue comparators |
| chan_sel | output | AW | Latched channel address driving the input multiplexer |
| data_out | output | 8 | Result register |
| data_oe | output | 1 | Enable for the three-state data bus |
| int_n | output | 1 | Active-low end-of-conversion flag |
| ready_drive | output | 1 | 1 = pull the open-drain ready line low |

## Verification
The assertions assume that cs_n, rd_n and chan_addr are synchronous to clk. They also assume that mode_pipe changes only while no access is open and no conversion is running, because data_oe and ready_drive follow it combinationally. The bench drives every input on the falling clock edge and changes the mode only between conversions, after cs_n has returned high. The thermometer inputs are under no such constraint: during random runs they change on every cycle, so that a sample taken one edge early or late shows up as a wrong result.

// File: rtl/hfadc_bus_ctrl.sv
module hfadc_bus_ctrl #(
  parameter int CLK_NS   = 4,
  parameter int TRACK_NS = 1000,
  parameter int FINE_NS  = 600,
  parameter int AW       = 3,
  parameter int NB       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [AW-1:0]     chan_addr,
  input  logic              mode_pipe,
  input  logic [(1<<NB)-2:0] coarse_therm,
  input  logic [(1<<NB)-2:0] fine_therm,
  output logic [AW-1:0]     chan_sel,
  output logic [2*NB-1:0]   data_out,
  output logic              data_oe,
  output logic              int_n,
  output logic              ready_drive
);
  localparam int TW        = (1 << NB) - 1;
  localparam int TRACK_CYC = TRACK_NS / CLK_NS;
  localparam int FINE_CYC  = FINE_NS / CLK_NS;
  localparam int MAXC      = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC;
  localparam int CW        = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_TRACK, S_FINE} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [NB-1:0]     upper;
  logic [2*NB-1:0]   result;
  logic              sel_q, rel;

  function automatic logic [NB-1:0] run_len(input logic [TW-1:0] t);
    logic [NB-1:0] n;
    logic          go;
    n  = '0;
    go = 1'b1;
    for (int i = 0; i < TW; i++) begin
      if (go && t[i]) n = n + NB'(1);
      else            go = 1'b0;
    end
    return n;
  endfunction

  wire sel      = !cs_n && !rd_n;
  wire busy     = (state != S_IDLE);
  wire start    = !busy && sel && !sel_q;
  wire trk_end  = (state == S_TRACK) && (cnt == CW'(TRACK_CYC - 1));
  wire fin      = (state == S_FINE)  && (cnt == CW'(FINE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      upper    <= '0;
      result   <= '0;
      chan_sel <= '0;
      sel_q    <= 1'b0;
      rel      <= 1'b0;
      int_n    <= 1'b1;
    end else begin
      sel_q <= sel;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_TRACK;
          cnt      <= '0;
          chan_sel <= chan_addr;
        end
        S_TRACK: if (trk_end) begin
          upper <= run_len(coarse_therm);
          cnt   <= '0;
          state <= S_FINE;
        end else cnt <= cnt + CW'(1);
        S_FINE: if (fin) begin
          result <= {upper, run_len(fine_therm)};
          state  <= S_IDLE;
        end else cnt <= cnt + CW'(1);
        default: state <= S_IDLE;
      endcase
      if (fin)                int_n <= 1'b0;
      else if (sel_q && !sel) int_n <= 1'b1;
      if (cs_n || start)      rel <= 1'b0;
      else if (fin)           rel <= 1'b1;
    end
  end

  assign data_out    = result;
  assign data_oe     = mode_pipe ? sel : (sel && sel_q && !busy);
  assign ready_drive = !cs_n && (mode_pipe || !rel);

  // R2
  start_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sel) && !$past(sel_q));
  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_sel));
  // R6
  int_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> ($past(state) == S_FINE) && (state == S_IDLE));
  // R7
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pipe && busy) |-> !data_oe);
  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pipe && busy && !cs_n) |-> ready_drive);
  // R3
  result_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != S_FINE) |-> $stable(result));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(MAXC));
endmodule

// File: tb/hfadc_bus_ctrl_bench.sv
module hfadc_bus_ctrl_bench;
  localparam int TRACK = 250;
  localparam int FINE  = 150;

  logic        clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, mode_pipe = 0;
  logic [2:0]  chan_addr = '0;
  logic [14:0] coarse_therm = '0, fine_therm = '0;
  logic [2:0]  chan_sel;
  logic [7:0]  data_out;
  logic        data_oe, int_n, ready_drive;

  hfadc_bus_ctrl u_hfadc_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .chan_addr(chan_addr),
    .mode_pipe(mode_pipe), .coarse_therm(coarse_therm), .fine_therm(fine_therm),
    .chan_sel(chan_sel), .data_out(data_out), .data_oe(data_oe),
    .int_n(int_n), .ready_drive(ready_drive));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0, rand_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ones_run(logic [14:0] t);
    int k = 0;
    while (k < 15 && t[k]) k++;
    return k;
  endfunction

  // behavioural reference model
  bit m_busy, m_int_n = 1, m_rel, m_prev;
  int m_age, m_upper, m_result, m_chan;

  always @(posedge clk) begin
    bit s, done_now;
    s = !cs_n && !rd_n;
    done_now = 0;
    if (!rst_n) begin
      m_busy = 0; m_int_n = 1; m_rel = 0; m_prev = 0;
      m_age = 0; m_upper = 0; m_result = 0; m_chan = 0;
    end else begin
      if (m_busy) begin
        m_age++;
        if (m_age == TRACK) m_upper = ones_run(coarse_therm);
        if (m_age == TRACK + FINE) begin
          m_result = m_upper * 16 + ones_run(fine_therm);
          m_busy = 0;
          done_now = 1;
        end
      end else if (s && !m_prev) begin
        m_busy = 1; m_age = 0; m_chan = chan_addr;
        if (!cs_n) m_rel = 0;
      end
      if (done_now) m_int_n = 0;
      else if (m_prev && !s) m_int_n = 1;
      if (cs_n) m_rel = 0;
      else if (done_now) m_rel = 1;
      m_prev = s;
    end
    #1;
    if (rst_n) begin
      bit e_oe;
      e_oe = mode_pipe ? s : (s && !m_busy);
      chk("R6 int_n", int_n, m_int_n);
      chk(mode_pipe ? "R9 data_oe" : "R7 data_oe", data_oe, e_oe);
      chk(mode_pipe ? "R10 ready" : "R8 ready", ready_drive,
          !cs_n && (mode_pipe || !m_rel));
      chk("R2 chan_sel", chan_sel, m_chan);
      if (e_oe) chk("R3 data_out", data_out, m_result);
    end
  end

  always @(negedge clk) if (rand_on) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    coarse_therm <= (lfsr[3:0] < 8) ? 15'((1 << lfsr[3:0]) - 1) : lfsr[14:0];
    fine_therm   <= {lfsr[6:0], lfsr[15:8]};
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // stalled-mode conversion; returns cycles until int_n low
  task automatic conv0(logic [2:0] a, output int n);
    chan_addr = a; cs_n = 0;
    cyc(2);
    chk("R8 ready before read", ready_drive, 1);
    rd_n = 0;
    n = 0;
    do begin cyc(1); n++; end while (int_n && n < 2000);
  endtask

  task automatic release_bus();
    rd_n = 1; cs_n = 1;
    cyc(1);
    chk("R6 int_n back high", int_n, 1);
    chk("R7 bus released", data_oe, 0);
    cyc(2);
  endtask

  initial begin
    int n;
    cyc(3);
    chk("R1 int_n", int_n, 1);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 ready", ready_drive, 0);
    chk("R1 data", data_out, 0);
    rst_n = 1;
    cyc(2);
    chk("R1 int_n after reset", int_n, 1);

    coarse_therm = 15'h00FF; fine_therm = 15'h0007;
    conv0(3'd5, n);
    chk("R6 completion latency", n, TRACK + FINE + 1);
    chk("R3 result", data_out, 8'h83);
    chk("R7 data_oe after end", data_oe, 1);
    chk("R8 ready released", ready_drive, 0);
    chk("R2 chan_sel", chan_sel, 5);
    release_bus();

    coarse_therm = 15'h005F; fine_therm = 15'h7FFF;
    conv0(3'd2, n);
    chk("R4 bubble decode", data_out, 8'h5F);
    release_bus();

    coarse_therm = 15'h7FFF; fine_therm = 15'h7FFF;
    conv0(3'd1, n);
    chk("R5 full scale", data_out, 8'hFF);
    release_bus();
    coarse_therm = 15'h0000; fine_therm = 15'h0000;
    conv0(3'd0, n);
    chk("R5 zero scale", data_out, 8'h00);
    chk("R5 zero data_oe", data_oe, 1);
    release_bus();

    mode_pipe = 1;
    coarse_therm = 15'h0FFF; fine_therm = 15'h0001;
    chan_addr = 3'd6; cs_n = 0; rd_n = 0;
    n = 0;
    for (int k = 1; k < 2000; k++) begin
      cyc(1);
      if (k == 1) begin
        chk("R9 previous result", data_out, 8'h00);
        chk("R9 data_oe", data_oe, 1);
        chk("R10 ready low", ready_drive, 1);
      end
      if (!int_n) begin n = k; break; end
      if (k == 3) begin
        cs_n = 1; rd_n = 1; #1;
        chk("R10 ready on cs rise", ready_drive, 0);
      end
      if (k == 150) begin chan_addr = 3'd7; cs_n = 0; rd_n = 0; end
      if (k == 153) begin cs_n = 1; rd_n = 1; end
    end
    chk("R11 latency unchanged", n, TRACK + FINE + 1);
    chk("R11 chan_sel kept", chan_sel, 6);
    chan_addr = 3'd4; cs_n = 0; rd_n = 0;
    cyc(1);
    chk("R9 result of last conversion", data_out, 8'hC1);
    chk("R2 new address", chan_sel, 4);
    cs_n = 1; rd_n = 1;
    cyc(TRACK + FINE + 5);

    rand_on = 1;
    for (int r = 0; r < 6; r++) begin
      mode_pipe = r[0];
      chan_addr = 3'(r);
      cs_n = 0; rd_n = 0;
      cyc(r[0] ? 2 : TRACK + FINE + 4);
      cs_n = 1; rd_n = 1;
      cyc(r[0] ? TRACK + FINE + 4 : 3);
    end
    rand_on = 0;
    chk("R3 random final result", data_out, m_result);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule